// File: doc/BRIEF.md
# Packet Transmit Framer

This block turns a packet held in a byte-wide buffer into a serial bit stream for a radio modulator. A single start strobe begins a frame. The block then sends the enabled fields in a fixed order: an optional preamble of alternating bits, an optional sync word of 8 to 32 bits, the payload bytes read from the buffer, and an optional 16-bit CRC computed over the payload. The modulator supplies a one-cycle bit-rate tick. Each tick advances the output by one symbol.

The configuration is captured when start is accepted, so software may change it while a frame is in flight. Three codings apply to the payload and CRC and never to the preamble or sync: none, Manchester (two chips per data bit) and PN9 whitening. When the last symbol has had its full period on the line, a one-cycle done pulse marks the end of the frame.

Top module: `pkt_tx_framer`

## Requirements
- R1: While reset is asserted and while idle, `tx_bit`, `tx_active` and `done_irq` are all 0.
- R2: A frame sends preamble, then sync word, then payload, then CRC. A field that is disabled or has zero length is skipped entirely, and the symbol count equals the sum of the enabled fields.
- R3: With `cfg_pre_en` set, the preamble is `cfg_pre_bytes` bytes of 0xAA sent MSB first, so the first symbol is 1. With a count of 0 the preamble is absent.
- R4: With `cfg_sync_en` set, the sync word is the low L bits of `cfg_sync_word`, sent from bit L-1 down to bit 0. L is `cfg_sync_len` clamped to the range 8..32.
- R5: The payload is `cfg_pay_len` bytes read from buffer addresses 0 upward, each byte MSB first. A length above 240 is clamped to 240. `buf_rdata` is a combinational read of `buf_addr`, and `buf_addr` stays below 240.
- R6: The CRC uses polynomial 0x1021 with initial value 0xFFFF. It is fed the uncoded payload bits MSB first, sent MSB first, and present only with `cfg_crc_en`. The payload "123456789" gives 0x29B1.
- R7: When `cfg_code` is 1 (Manchester), each payload and CRC bit becomes two chips, one per tick: a 1 is sent as 1 then 0, and a 0 as 0 then 1.
- R8: When `cfg_code` is 2 (whitening), each payload and CRC bit is XORed with the LSB of a 9-bit state seeded to all ones at frame start. After each bit, the state shifts right and its new bit 8 is old bit 0 XOR old bit 5.
- R9: When `cfg_code` is 0 or 3, the payload and CRC are sent uncoded.
- R10: `tx_bit` changes only on cycles following a `bit_tick`. The first symbol appears after the first tick that follows the accepted start. `tx_active` rises in the cycle after an idle start.
- R11: `done_irq` is high for exactly one cycle, in the cycle after the tick that ends the last symbol's period. `tx_active` is 0 in that cycle. A frame with no fields ends on its first tick.
- R12: A start pulse during a frame is ignored, and configuration changes during a frame do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame when idle |
| bit_tick | input | 1 | One-cycle symbol-rate enable |
| cfg_pre_en | input | 1 | Preamble enable |
| cfg_pre_bytes | input | 8 | Preamble length in bytes |
| cfg_sync_en | input | 1 | Sync word enable |
| cfg_sync_len | input | 6 | Sync length in bits (clamped 8..32) |
| cfg_sync_word | input | 32 | Sync pattern, right-aligned |
| cfg_pay_len | input | 8 | Payload length in bytes (clamped to 240) |
| cfg_crc_en | input | 1 | CRC append enable |
| cfg_code | input | 2 | 0 none, 1 Manchester, 2 whitening, 3 none |
| buf_addr | output | 8 | Packet buffer read address |
| buf_rdata | input | 8 | Packet buffer read data |
| tx_bit | output | 1 | Serial symbol output |
| tx_active | output | 1 | Frame in progress |
| done_irq | output | 1 | One-cycle end-of-frame pulse |

## Verification
The hardest situations to reach are the ones that arise deep inside a long frame. The clamp at 240 bytes only matters once the payload counter approaches the buffer end. A Manchester chip pair that straddles a byte boundary only matters mid-payload, and so does a start or configuration change during a busy frame. The stimulus reaches these cases in three ways. It requests 250 bytes at one tick per cycle and counts every symbol. It sends a Manchester frame whose ticks come every other cycle. It pulses start and rewrites the coding, sync word and length midway through that frame. The behavioural model captures the configuration only at the accepted start, so any leak of the new settings shows up as a symbol mismatch.

// File: rtl/txf_pkg.sv
package txf_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_PRE  = 3'd1,
    S_SYNC = 3'd2,
    S_PAY  = 3'd3,
    S_CRC  = 3'd4,
    S_FIN  = 3'd5
  } txf_state_e;

  typedef enum logic [1:0] {
    CODE_NONE = 2'd0,
    CODE_MAN  = 2'd1,
    CODE_WHT  = 2'd2,
    CODE_RSV  = 2'd3
  } txf_code_e;

  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;
  localparam logic [8:0]  PN_SEED  = 9'h1FF;

endpackage

// File: rtl/txf_crc16.sv
module txf_crc16
  import txf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        upd,
  input  logic        shl,
  input  logic        din,
  output logic [15:0] crc_q
);

  logic [15:0] crc_d;
  logic        fb;

  always_comb begin
    fb    = crc_q[15] ^ din;
    crc_d = crc_q;
    if (init) begin
      crc_d = CRC_SEED;
    end else if (upd) begin
      crc_d = {crc_q[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    end else if (shl) begin
      crc_d = {crc_q[14:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= CRC_SEED;
    end else if (init || upd || shl) begin
      crc_q <= crc_d;
    end
  end

endmodule

// File: rtl/txf_pn9.sv
module txf_pn9
  import txf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic adv,
  output logic pn_bit
);

  logic [8:0] st_q;
  logic [8:0] st_d;

  always_comb begin
    st_d = st_q;
    if (init) begin
      st_d = PN_SEED;
    end else if (adv) begin
      st_d = {st_q[0] ^ st_q[5], st_q[8:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= PN_SEED;
    end else if (init || adv) begin
      st_q <= st_d;
    end
  end

  assign pn_bit = st_q[0];

endmodule

// File: rtl/txf_cfg_norm.sv
module txf_cfg_norm
  import txf_pkg::*;
#(
  parameter int PRE_W    = 8,
  parameter int LEN_W    = 8,
  parameter int MAX_PAY  = 240,
  parameter int SYNC_MAX = 32,
  parameter int SYNC_MIN = 8,
  localparam int SLW     = $clog2(SYNC_MAX + 1)
) (
  input  logic             pre_en,
  input  logic [PRE_W-1:0] pre_bytes,
  input  logic             sync_en,
  input  logic [SLW-1:0]   sync_len,
  input  logic [LEN_W-1:0] pay_len,
  input  logic             crc_en,
  input  logic [1:0]       code,
  output logic [SLW-1:0]   sync_len_n,
  output logic [LEN_W-1:0] pay_len_n,
  output logic             has_pre,
  output logic             has_sync,
  output logic             has_pay,
  output logic             has_crc,
  output logic [1:0]       code_n
);

  always_comb begin
    if (sync_len < SLW'(SYNC_MIN)) begin
      sync_len_n = SLW'(SYNC_MIN);
    end else if (sync_len > SLW'(SYNC_MAX)) begin
      sync_len_n = SLW'(SYNC_MAX);
    end else begin
      sync_len_n = sync_len;
    end
    pay_len_n = (pay_len > LEN_W'(MAX_PAY)) ? LEN_W'(MAX_PAY) : pay_len;
    has_pre   = pre_en && (pre_bytes != '0);
    has_sync  = sync_en;
    has_pay   = (pay_len_n != '0);
    has_crc   = crc_en;
    code_n    = (code == CODE_RSV) ? CODE_NONE : code;
  end

endmodule

// File: rtl/pkt_tx_framer.sv
module pkt_tx_framer
  import txf_pkg::*;
#(
  parameter int PRE_W    = 8,
  parameter int LEN_W    = 8,
  parameter int MAX_PAY  = 240,
  parameter int SYNC_MAX = 32,
  localparam int SLW     = $clog2(SYNC_MAX + 1),
  localparam int CW      = ((PRE_W > LEN_W) ? PRE_W : LEN_W) + 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                bit_tick,
  input  logic                cfg_pre_en,
  input  logic [PRE_W-1:0]    cfg_pre_bytes,
  input  logic                cfg_sync_en,
  input  logic [SLW-1:0]      cfg_sync_len,
  input  logic [SYNC_MAX-1:0] cfg_sync_word,
  input  logic [LEN_W-1:0]    cfg_pay_len,
  input  logic                cfg_crc_en,
  input  logic [1:0]          cfg_code,
  output logic [LEN_W-1:0]    buf_addr,
  input  logic [7:0]          buf_rdata,
  output logic                tx_bit,
  output logic                tx_active,
  output logic                done_irq
);

  // normalised live configuration
  logic [SLW-1:0]   n_sync_len;
  logic [LEN_W-1:0] n_pay_len;
  logic             n_pre, n_sync, n_pay, n_crc;
  logic [1:0]       n_code;

  txf_cfg_norm #(
    .PRE_W(PRE_W), .LEN_W(LEN_W), .MAX_PAY(MAX_PAY), .SYNC_MAX(SYNC_MAX), .SYNC_MIN(8)
  ) u_norm (
    .pre_en(cfg_pre_en), .pre_bytes(cfg_pre_bytes), .sync_en(cfg_sync_en),
    .sync_len(cfg_sync_len), .pay_len(cfg_pay_len), .crc_en(cfg_crc_en), .code(cfg_code),
    .sync_len_n(n_sync_len), .pay_len_n(n_pay_len), .has_pre(n_pre), .has_sync(n_sync),
    .has_pay(n_pay), .has_crc(n_crc), .code_n(n_code)
  );

  // frame-captured configuration
  logic [PRE_W-1:0]    pre_bytes_q;
  logic [SLW-1:0]      sync_len_q;
  logic [SYNC_MAX-1:0] sync_word_q;
  logic [LEN_W-1:0]    pay_len_q;
  logic [1:0]          code_q;
  logic                hp_q, hs_q, hd_q, hc_q;

  // sequencing state
  txf_state_e     st_q, st_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           half_q, half_d;
  logic           bit_q, bit_d;
  logic           done_q, done_d;
  logic [7:0]     byte_q, byte_d;
  logic           latch, init;
  logic           crc_upd, crc_shl, pn_adv;

  logic [15:0]    crc_val;
  logic           pn_bit;

  // field bookkeeping
  logic           hp, hs, hd, hc;
  logic           coded, man, wht, data_step;
  logic [CW-1:0]  last_idx;
  logic [2:0]     bp;
  logic [SLW-1:0] sync_idx;
  logic [SYNC_MAX-1:0] sync_sh;
  logic           raw, sym;
  txf_state_e     nxt, first;

  function automatic txf_state_e follow(txf_state_e s, logic p, logic y, logic d, logic c);
    txf_state_e r;
    r = S_FIN;
    case (s)
      S_IDLE:  r = p ? S_PRE : (y ? S_SYNC : (d ? S_PAY : (c ? S_CRC : S_FIN)));
      S_PRE:   r = y ? S_SYNC : (d ? S_PAY : (c ? S_CRC : S_FIN));
      S_SYNC:  r = d ? S_PAY : (c ? S_CRC : S_FIN);
      S_PAY:   r = c ? S_CRC : S_FIN;
      default: r = S_FIN;
    endcase
    return r;
  endfunction

  txf_crc16 u_crc (
    .clk(clk), .rst_n(rst_n), .init(init), .upd(crc_upd), .shl(crc_shl),
    .din(raw), .crc_q(crc_val)
  );

  txf_pn9 u_pn9 (
    .clk(clk), .rst_n(rst_n), .init(init), .adv(pn_adv), .pn_bit(pn_bit)
  );

  always_comb begin
    hp = (st_q == S_IDLE) ? n_pre  : hp_q;
    hs = (st_q == S_IDLE) ? n_sync : hs_q;
    hd = (st_q == S_IDLE) ? n_pay  : hd_q;
    hc = (st_q == S_IDLE) ? n_crc  : hc_q;
    first = follow(S_IDLE, hp, hs, hd, hc);
    nxt   = follow(st_q, hp, hs, hd, hc);

    coded     = (st_q == S_PAY) || (st_q == S_CRC);
    man       = coded && (code_q == CODE_MAN);
    wht       = coded && (code_q == CODE_WHT);
    data_step = !man || half_q;

    case (st_q)
      S_PRE:   last_idx = CW'({pre_bytes_q - 1'b1, 3'b111});
      S_SYNC:  last_idx = CW'(sync_len_q - 1'b1);
      S_PAY:   last_idx = CW'({pay_len_q - 1'b1, 3'b111});
      default: last_idx = CW'(15);
    endcase

    bp       = cnt_q[2:0];
    sync_idx = sync_len_q - 1'b1 - cnt_q[SLW-1:0];
    sync_sh  = sync_word_q >> sync_idx;

    case (st_q)
      S_PRE:   raw = ~cnt_q[0];
      S_SYNC:  raw = sync_sh[0];
      S_PAY:   raw = (bp == 3'd0 && !half_q) ? buf_rdata[7] : byte_q[~bp];
      S_CRC:   raw = crc_val[15];
      default: raw = 1'b0;
    endcase

    if (man) begin
      sym = half_q ? ~raw : raw;
    end else if (wht) begin
      sym = raw ^ pn_bit;
    end else begin
      sym = raw;
    end
  end

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    half_d  = half_q;
    bit_d   = bit_q;
    done_d  = 1'b0;
    byte_d  = byte_q;
    latch   = 1'b0;
    init    = 1'b0;
    crc_upd = 1'b0;
    crc_shl = 1'b0;
    pn_adv  = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (start) begin
          latch  = 1'b1;
          init   = 1'b1;
          st_d   = first;
          cnt_d  = '0;
          half_d = 1'b0;
        end
      end
      S_FIN: begin
        if (bit_tick) begin
          bit_d  = 1'b0;
          done_d = 1'b1;
          st_d   = S_IDLE;
        end
      end
      default: begin
        if (bit_tick) begin
          bit_d = sym;
          if (st_q == S_PAY && bp == 3'd0 && !half_q) begin
            byte_d = buf_rdata;
          end
          if (data_step) begin
            half_d  = 1'b0;
            crc_upd = (st_q == S_PAY);
            crc_shl = (st_q == S_CRC);
            pn_adv  = wht;
            if (cnt_q == last_idx) begin
              cnt_d = '0;
              st_d  = nxt;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end else begin
            half_d = 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      half_q <= 1'b0;
      bit_q  <= 1'b0;
      done_q <= 1'b0;
      byte_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      half_q <= half_d;
      bit_q  <= bit_d;
      done_q <= done_d;
      byte_q <= byte_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_bytes_q <= '0;
      sync_len_q  <= '0;
      sync_word_q <= '0;
      pay_len_q   <= '0;
      code_q      <= CODE_NONE;
      hp_q        <= 1'b0;
      hs_q        <= 1'b0;
      hd_q        <= 1'b0;
      hc_q        <= 1'b0;
    end else if (latch) begin
      pre_bytes_q <= cfg_pre_bytes;
      sync_len_q  <= n_sync_len;
      sync_word_q <= cfg_sync_word;
      pay_len_q   <= n_pay_len;
      code_q      <= n_code;
      hp_q        <= n_pre;
      hs_q        <= n_sync;
      hd_q        <= n_pay;
      hc_q        <= n_crc;
    end
  end

  assign buf_addr  = (st_q == S_PAY) ? cnt_q[LEN_W+2:3] : '0;
  assign tx_bit    = bit_q;
  assign tx_active = (st_q != S_IDLE);
  assign done_irq  = done_q;

endmodule

// File: rtl/txf_checker.sv
module txf_checker #(
  parameter int LEN_W   = 8,
  parameter int MAX_PAY = 240
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             bit_tick,
  input logic             tx_bit,
  input logic             tx_active,
  input logic             done_irq,
  input logic [LEN_W-1:0] buf_addr
);

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> !tx_active);

  assert_hold_no_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(tx_bit));

  assert_start_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !tx_active) |=> tx_active);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_active |-> !tx_bit);

  assert_addr_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    buf_addr < LEN_W'(MAX_PAY));

  assert_done_after_active_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_irq) |-> $past(tx_active));

endmodule

bind pkt_tx_framer txf_checker #(.LEN_W(LEN_W), .MAX_PAY(MAX_PAY)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .bit_tick(bit_tick), .tx_bit(tx_bit),
  .tx_active(tx_active), .done_irq(done_irq), .buf_addr(buf_addr)
);

// File: tb/tb_pkt_tx_framer.sv
module tb_pkt_tx_framer;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        start = 1'b0, bit_tick = 1'b0;
  logic        cfg_pre_en = 1'b0, cfg_sync_en = 1'b0, cfg_crc_en = 1'b0;
  logic [7:0]  cfg_pre_bytes = '0, cfg_pay_len = '0;
  logic [5:0]  cfg_sync_len = '0;
  logic [31:0] cfg_sync_word = '0;
  logic [1:0]  cfg_code = '0;
  logic [7:0]  buf_addr, buf_rdata;
  logic        tx_bit, tx_active, done_irq;
  logic [7:0]  mem [0:255];

  assign buf_rdata = mem[buf_addr];

  pkt_tx_framer dut (
    .clk(clk), .rst_n(rst_n), .start(start), .bit_tick(bit_tick),
    .cfg_pre_en(cfg_pre_en), .cfg_pre_bytes(cfg_pre_bytes), .cfg_sync_en(cfg_sync_en),
    .cfg_sync_len(cfg_sync_len), .cfg_sync_word(cfg_sync_word), .cfg_pay_len(cfg_pay_len),
    .cfg_crc_en(cfg_crc_en), .cfg_code(cfg_code), .buf_addr(buf_addr), .buf_rdata(buf_rdata),
    .tx_bit(tx_bit), .tx_active(tx_active), .done_irq(done_irq)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit cmp_on = 1'b0;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference
  bit    q_b[$];
  string q_t[$];
  bit    cap[$];
  bit    m_active = 1'b0, m_bit = 1'b0, m_done = 1'b0, m_pop = 1'b0;
  string m_tag = "R10";
  int    exp_len = 0;
  int    pn;

  task automatic emit(bit d, string tag, int code);
    if (code == 1) begin
      q_b.push_back(d);  q_t.push_back("R7");
      q_b.push_back(!d); q_t.push_back("R7");
    end else if (code == 2) begin
      q_b.push_back(d ^ pn[0]); q_t.push_back("R8");
      pn = (pn >> 1) | (((pn ^ (pn >> 5)) & 1) << 8);
    end else begin
      q_b.push_back(d); q_t.push_back(code == 3 ? "R9" : tag);
    end
  endtask

  task automatic build();
    int L, n, crc, code;
    bit d, fb;
    q_b.delete(); q_t.delete();
    code = int'(cfg_code);
    pn   = 9'h1FF;
    if (cfg_pre_en)
      for (int i = 0; i < int'(cfg_pre_bytes) * 8; i++) begin
        q_b.push_back(i % 2 == 0); q_t.push_back("R3");
      end
    if (cfg_sync_en) begin
      L = int'(cfg_sync_len);
      if (L < 8) L = 8;
      if (L > 32) L = 32;
      for (int i = L - 1; i >= 0; i--) begin
        q_b.push_back(cfg_sync_word[i]); q_t.push_back("R4");
      end
    end
    n = int'(cfg_pay_len);
    if (n > 240) n = 240;
    crc = 16'hFFFF;
    for (int b = 0; b < n; b++)
      for (int i = 7; i >= 0; i--) begin
        d   = mem[b][i];
        fb  = crc[15] ^ d;
        crc = ((crc << 1) & 16'hFFFF) ^ (fb ? 16'h1021 : 0);
        emit(d, "R5", code);
      end
    if (cfg_crc_en)
      for (int i = 15; i >= 0; i--) emit(crc[i], "R6", code);
    exp_len = q_b.size();
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_active = 1'b0; m_bit = 1'b0; m_done = 1'b0; m_pop = 1'b0;
    end else begin
      m_done = 1'b0;
      m_pop  = 1'b0;
      if (!m_active) begin
        if (start) begin
          build();
          m_active = 1'b1;
        end
      end else if (bit_tick) begin
        if (q_b.size() > 0) begin
          m_bit = q_b.pop_front();
          m_tag = q_t.pop_front();
          m_pop = 1'b1;
        end else begin
          m_bit = 1'b0; m_active = 1'b0; m_done = 1'b1; m_tag = "R11";
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk(tx_bit == m_bit, m_tag, "tx_bit", tx_bit, m_bit);
      chk(tx_active == m_active, "R10", "tx_active", tx_active, m_active);
      chk(done_irq == m_done, "R11", "done_irq", done_irq, m_done);
      if (m_pop) cap.push_back(tx_bit);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL R10 watchdog: actual %0d expected <150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic set_cfg(bit pe, int pb, bit se, int sl, logic [31:0] sw, int pl, bit ce, int cd);
    cfg_pre_en = pe; cfg_pre_bytes = 8'(pb); cfg_sync_en = se; cfg_sync_len = 6'(sl);
    cfg_sync_word = sw; cfg_pay_len = 8'(pl); cfg_crc_en = ce; cfg_code = 2'(cd);
  endtask

  task automatic run_frame(int period, bit poke);
    int k;
    cap.delete();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    k = 0;
    forever begin
      bit_tick = (k % period == period - 1);
      start    = 1'b0;
      if (poke && k == 41) begin
        start = 1'b1;                         // R12: ignored while busy
        cfg_code = 2'd2; cfg_sync_word = 32'hFFFF0000; cfg_pay_len = 8'd1;
      end
      if (poke && k == 42) chk(tx_active == 1'b1, "R12", "busy after restart", tx_active, 1);
      @(negedge clk);
      k++;
      if (m_done || k > 20000) break;
    end
    bit_tick = 1'b0;
    start    = 1'b0;
    chk(cap.size() == exp_len, "R2", "symbol count", cap.size(), exp_len);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int v;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    repeat (3) @(negedge clk);
    chk(tx_bit == 1'b0 && tx_active == 1'b0 && done_irq == 1'b0, "R1", "reset outputs",
        {tx_bit, tx_active, done_irq}, 0);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    repeat (2) @(negedge clk);
    chk(tx_active == 1'b0, "R1", "idle after reset", tx_active, 0);

    set_cfg(1, 2, 1, 16, 32'h0000D391, 5, 1, 0);  run_frame(3, 0);
    set_cfg(1, 1, 1, 24, 32'h005A0F33, 6, 1, 1);  run_frame(2, 1);
    set_cfg(0, 0, 1, 32, 32'hDEADBEEF, 7, 1, 2);  run_frame(1, 0);
    set_cfg(1, 1, 1, 4,  32'h000000C3, 3, 0, 3);  run_frame(2, 0);
    set_cfg(0, 3, 1, 40, 32'h12345678, 2, 1, 1);  run_frame(1, 0);
    set_cfg(0, 0, 0, 8,  32'h0, 250, 1, 0);       run_frame(1, 0);
    chk(cap.size() == 240 * 8 + 16, "R5", "clamped length", cap.size(), 240 * 8 + 16);

    for (int i = 0; i < 9; i++) mem[i] = 8'(8'h31 + i);
    set_cfg(0, 0, 0, 8, 32'h0, 9, 1, 0);          run_frame(2, 0);
    v = 0;
    for (int i = cap.size() - 16; i < cap.size(); i++) v = (v << 1) | int'(cap[i]);
    chk(v == 16'h29B1, "R6", "check value", v, 16'h29B1);

    set_cfg(0, 0, 0, 8, 32'h0, 0, 0, 0);          run_frame(2, 0);
    chk(exp_len == 0, "R11", "empty frame length", exp_len, 0);
    set_cfg(1, 0, 1, 8, 32'h000000A5, 0, 1, 2);   run_frame(1, 0);

    cmp_on = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule